// File: doc/BRIEF.md
# Count/Compare Timer Interrupt

This block keeps a free-running cycle counter next to a writable compare value and raises a sticky timer interrupt request when the counter lands inside a fixed-size window that starts at the compare value. The window test uses modular arithmetic. The unsigned difference `count - compare`, taken modulo 2^CNT_W, must be below WINDOW (default 1000). A counter that has wrapped past zero therefore still matches a compare value set just below the top of the range.

The request is qualified by the processor status word. The check runs only when the status bits {16,2,1,0} read 1,0,0,1, which means the timer check domain is on, interrupts are enabled, and neither the exception level nor the error level is active. The timer-enable status bit 15 must also be set. A pending request shows a cause code of 0x0080_8000 on the cause output, and the request stays up until software writes a new compare value.

Top module: `cc_timer`

## Requirements
- R1: While reset is asserted and right after it is released, count, compare, irq and cause are all zero.
- R2: count rises by exactly one on every clock edge where adv_en is 1, holds when adv_en is 0, and wraps from 2^CNT_W-1 to 0.
- R3: When cmp_wr is 1 at a clock edge, compare takes cmp_wdata from that edge onward. Otherwise compare holds.
- R4: A window hit is defined as ((count - compare) mod 2^CNT_W) < WINDOW, using the values of count and compare before the edge. An offset of WINDOW-1 hits and an offset of WINDOW does not.
- R5: irq can be set at an edge only if, at that edge, (status & 0x0001_0007) == 0x0001_0001, status bit 15 is 1, and there is a window hit. If any of these is false, irq is not set.
- R6: Once set, irq stays at 1 on every later edge until a compare write, even after count leaves the window.
- R7: A compare write clears irq at that edge, and the clear wins over a window hit in the same cycle.
- R8: cause equals 0x0080_8000 whenever irq is 1 and equals 0 whenever irq is 0.
- R9: The window test is taken modulo 2^CNT_W. With compare near the top of the range, a count that has wrapped past zero by less than WINDOW - (2^CNT_W - compare) still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Counter advance enable, one count per enabled cycle |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare write data |
| status | input | 32 | Processor status word used to gate the check |
| count | output | CNT_W | Current counter value |
| compare | output | CNT_W | Current compare value |
| irq | output | 1 | Pending timer interrupt request |
| cause | output | 32 | Cause code of the pending request, zero when idle |

## Verification
The assertions assume every input is a known value at each clock edge and that WINDOW is smaller than 2^CNT_W, so that the modular window is a proper subrange. The bench builds the timer with a 12-bit counter, which lets wraparound be reached within a few thousand cycles while keeping WINDOW at 1000. It draws status words so that most of them satisfy the gate pattern with the other bits random, and the remainder are fully random. It places compare writes at random offsets behind the running count, so that hits, misses, wrapped hits and clears racing a hit all occur.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [31:0] TMR_CAUSE      = 32'h0080_8000;
    localparam logic [31:0] GATE_MASK      = 32'h0001_0007;
    localparam logic [31:0] GATE_MATCH     = 32'h0001_0001;
    localparam int          TMR_ENABLE_BIT = 15;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_window.sv
module tmr_window #(
    parameter int CNT_W  = 32,
    parameter int WINDOW = 1000
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WINDOW);
    logic [CNT_W-1:0] offset;

    always_comb begin
        offset = cnt_i - cmp_i;
        hit_o  = (offset < WIN_LIM);
    end
endmodule

// File: rtl/tmr_gate.sv
module tmr_gate
    import tmr_pkg::*;
(
    input  logic [31:0] status_i,
    output logic        arm_o
);
    always_comb begin
        arm_o = ((status_i & GATE_MASK) == GATE_MATCH) && status_i[TMR_ENABLE_BIT];
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WINDOW = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [31:0]      status,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] compare,
    output logic             irq,
    output logic [31:0]      cause
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             pend;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_w;
    logic             hit_w;
    logic             arm_w;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv_en),
        .cnt_o (cnt_w)
    );

    tmr_window #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_win (
        .cnt_i (cnt_w),
        .cmp_i (st_q.cmp),
        .hit_o (hit_w)
    );

    tmr_gate u_gate (
        .status_i (status),
        .arm_o    (arm_w)
    );

    always_comb begin
        st_d = st_q;
        if (cmp_wr) begin
            st_d.cmp  = cmp_wdata;
            st_d.pend = 1'b0;
        end else if (arm_w && hit_w) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = cnt_w;
    assign compare = st_q.cmp;
    assign irq     = st_q.pend;
    assign cause   = st_q.pend ? TMR_CAUSE : 32'h0;
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WINDOW = 1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv_en,
    input logic             cmp_wr,
    input logic [CNT_W-1:0] cmp_wdata,
    input logic [31:0]      status,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] compare,
    input logic             irq,
    input logic [31:0]      cause
);
    logic [CNT_W-1:0] gap;
    assign gap = count - compare;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> count == $past(count) + 1'b1);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(count));

    assert_cmp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> compare == $past(cmp_wdata));

    assert_irq_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past((status & GATE_MASK) == GATE_MATCH) && $past(status[TMR_ENABLE_BIT])
                        && ($past(gap) < CNT_W'(WINDOW))));

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cmp_wr) |=> irq);

    assert_wr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !irq);

    always_comb begin
        if (rst_n) begin
            assert_cause_match_R8: assert (cause == (irq ? TMR_CAUSE : 32'h0));
        end
    end
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_chk (.*);

// File: tb/cc_timer_tb.sv
`timescale 1ns/100ps
module cc_timer_tb;
    localparam int CW  = 12;
    localparam int WIN = 1000;
    localparam logic [31:0] GOOD = 32'h0001_8001;
    localparam logic [31:0] BAD  = 32'h0001_8003;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_en = 1'b0;
    logic          cmp_wr = 1'b0;
    logic [CW-1:0] cmp_wdata = '0;
    logic [31:0]   status = '0;
    logic [CW-1:0] count, compare;
    logic          irq;
    logic [31:0]   cause;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_cmp = '0;
    logic          m_pend = 1'b0;

    always #2.5 clk = ~clk;

    cc_timer #(.CNT_W(CW), .WINDOW(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .status(status), .count(count),
        .compare(compare), .irq(irq), .cause(cause)
    );

    function automatic logic in_win(logic [CW-1:0] c, logic [CW-1:0] p);
        logic [CW-1:0] d;
        d = c - p;
        return d < CW'(WIN);
    endfunction

    function automatic logic gated(logic [31:0] s);
        return ((s & 32'h0001_0007) == 32'h0001_0001) && s[15];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(logic en, logic wr, logic [CW-1:0] d, logic [31:0] s, string tag);
        logic [CW-1:0] n_cnt, n_cmp;
        logic          n_pend;
        adv_en = en; cmp_wr = wr; cmp_wdata = d; status = s;
        n_cnt  = en ? m_cnt + 1'b1 : m_cnt;
        n_cmp  = wr ? d : m_cmp;
        n_pend = wr ? 1'b0 : (m_pend | (gated(s) & in_win(m_cnt, m_cmp)));
        @(posedge clk);
        @(negedge clk);
        m_cnt = n_cnt; m_cmp = n_cmp; m_pend = n_pend;
        chk("R2 count", 32'(count), 32'(m_cnt));
        chk("R3 compare", 32'(compare), 32'(m_cmp));
        chk({tag, " irq"}, 32'(irq), 32'(m_pend));
        chk("R8 cause", cause, m_pend ? 32'h0080_8000 : 32'h0);
    endtask

    task automatic advance_to(logic [CW-1:0] target);
        while (m_cnt != target) step(1'b1, 1'b0, '0, BAD, "R5");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 count", 32'(count), 0);
        chk("R1 compare", 32'(compare), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cause", cause, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after release", 32'(irq), 0);

        // R4: offset WIN-1 hits, offset WIN misses
        step(1'b0, 1'b1, 12'd100, BAD, "R7");
        advance_to(12'd100 + 12'(WIN) - 12'd1);
        step(1'b0, 1'b0, '0, GOOD, "R4");
        chk("R4 edge hit", 32'(irq), 1);
        // R6: stays after leaving window
        advance_to(12'd100 + 12'(WIN) + 12'd50);
        step(1'b0, 1'b0, '0, GOOD, "R6");
        chk("R6 sticky", 32'(irq), 1);
        step(1'b0, 1'b1, 12'd150, BAD, "R7");
        chk("R7 cleared", 32'(irq), 0);
        step(1'b0, 1'b0, '0, GOOD, "R4");
        chk("R4 offset WIN misses", 32'(irq), 0);

        // R5: each gate bit blocks the request while in window
        step(1'b0, 1'b1, m_cnt - 12'd5, BAD, "R7");
        step(1'b0, 1'b0, '0, 32'h0001_0001, "R5");
        chk("R5 bit15 clear", 32'(irq), 0);
        step(1'b0, 1'b0, '0, 32'h0000_8001, "R5");
        chk("R5 bit16 clear", 32'(irq), 0);
        step(1'b0, 1'b0, '0, 32'h0001_8000, "R5");
        chk("R5 bit0 clear", 32'(irq), 0);
        step(1'b0, 1'b0, '0, 32'h0001_8005, "R5");
        chk("R5 bit2 set", 32'(irq), 0);
        step(1'b0, 1'b0, '0, GOOD | 32'hFFFE_7FF8, "R5");
        chk("R5 other bits ignored", 32'(irq), 1);

        // R7: write and hit in the same cycle, clear wins
        step(1'b0, 1'b1, m_cnt, GOOD, "R7");
        chk("R7 clear beats hit", 32'(irq), 0);

        // R9: wrapped count still in window
        step(1'b0, 1'b1, 12'd4090, BAD, "R7");
        advance_to(12'd4095);
        step(1'b1, 1'b0, '0, BAD, "R2");
        chk("R2 wrap to zero", 32'(count), 0);
        advance_to(12'd5);
        step(1'b0, 1'b0, '0, GOOD, "R9");
        chk("R9 wrapped hit", 32'(irq), 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] s;
            logic        wr;
            logic [CW-1:0] d;
            if (($urandom % 4) != 0)
                s = (($urandom) & ~32'h0001_8007) | GOOD;
            else
                s = $urandom;
            wr = (($urandom % 16) == 0);
            d  = m_cnt - CW'($urandom % 1300);
            step(($urandom % 8) != 0, wr, d, s, "R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule